// File: doc/BRIEF.md
# Five-group cascaded interrupt controller

This block collects 160 interrupt sources into five groups of 32 and turns them into five CPU interrupt lines, one per group. Each source has a sticky pending bit, set by a rising edge on its input wire or by a software request, and cleared by a write-one acknowledge. A per-group enable word masks sources. A group's CPU line is asserted while any pending, enabled source remains in that group.

Software reaches the block through a plain 32-bit register port: address, write strobe, write data and read data. Reads are combinational on the current address. One shared vector word gives, for every group at once, the index of the lowest pending and enabled source. The interrupt handler can therefore pick its source with a single read. In group 0 the twelve lowest sources act as one unit: they are enabled, masked, acknowledged and reported together. A priority encoder names the lowest-numbered group whose line is active.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, all five CPU lines are low, and every register reads 0.
- R2: Group g (0..4) decodes at byte offset 0x10 + 0x10*g. Its words are: pending at +0x0, enable at +0x4, masked-pending at +0x8 and request-set at +0xC. The request-set word reads 0.
- R3: A 0-to-1 change of srcIn bit 32*g+i, seen at one clock edge, sets pending bit i of group g at that edge. A level that stays high does not set the bit again after an acknowledge.
- R4: Writing 1s to a group's request-set word sets the matching pending bits. Bits written as 0 are unchanged.
- R5: Writing 1s to a group's pending word clears the matching bits, and bits written as 0 are unchanged. If a bit is set and cleared in the same cycle, it ends up set.
- R6: The masked-pending word reads pending AND enable. cpuIrq[g] is the OR of group g's masked-pending bits.
- R7: The vector word at offset 0x60 holds a 5-bit field per group at bits [5g+4:5g]. Each field is the lowest pending, enabled index in its group, or 0 when there is none. Bits 25 to 31 read 0.
- R8: In group 0, enable bits 0..11 form one unit. An enable write with any 1 in bits 0..11 enables all twelve, and a write with none masks all twelve. A pending write with any 1 in bits 0..11 acknowledges all twelve.
- R9: While any group-0 source 0..11 is pending and enabled, vector field 0 reads 0. Field 0 therefore never reads 1..11.
- R10: irqAny is high when any CPU line is high. irqGrp then gives the lowest-numbered active group.
- R11: Reads of offsets 0x00..0x0C, of offsets above 0x60 and of misaligned addresses return 0, and writes to them change nothing. Writes to the masked-pending word and to the vector word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 160 | Interrupt source lines, bit 32*g+i is source i of group g |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| cpuIrq | output | 5 | One interrupt line per group |
| irqAny | output | 1 | Any CPU line active |
| irqGrp | output | 3 | Lowest-numbered active group |

## Verification
A wrong pending or enable bit reaches the ports in the same cycle. It appears on cpuIrq and irqGrp at once, and it appears in the next read of the masked-pending or vector word. This holds whether the fault comes from a missed edge, a lost acknowledge or a wrongly spread group-0 block. The bench keeps a behavioural model in step with the design and compares the CPU lines, the priority outputs and the read data on every clock. It exercises each directed corner, then runs a long stretch of random bus traffic with toggling sources, so a divergence is reported in the first cycle it becomes visible.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  // width of a group index carried in strobes and the priority output
  parameter int GIDX_W = 3;

  // register kind inside a group's 16-byte window, decoded from addr[3:2]
  typedef enum logic [1:0] {
    RK_STATUS = 2'd0,
    RK_ENABLE = 2'd1,
    RK_PEND   = 2'd2,
    RK_SET    = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                grpHit;
    logic                vecHit;
    logic                wr;
    regKind_e            kind;
    logic [GIDX_W-1:0]   grp;
  } busStrb_t;
endpackage

// File: rtl/irq_regctl.sv
module irq_regctl
  import irq_cascade_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrb_t          strb
);
  localparam int STRIDE_LOG2 = 4;
  localparam int BLK_W       = ADDR_W - STRIDE_LOG2;
  localparam logic [ADDR_W-1:0] VEC_OFF = ADDR_W'((NUM_GROUPS + 1) << STRIDE_LOG2);

  logic [BLK_W-1:0] blk;
  logic             aligned;

  always_comb begin
    blk         = busAddr[ADDR_W-1:STRIDE_LOG2];
    aligned     = (busAddr[1:0] == 2'b00);
    strb.grpHit = aligned && (blk >= BLK_W'(1)) && (blk <= BLK_W'(NUM_GROUPS));
    strb.vecHit = (busAddr == VEC_OFF);
    strb.wr     = busWe;
    strb.kind   = regKind_e'(busAddr[3:2]);
    strb.grp    = GIDX_W'(blk - BLK_W'(1));
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_cascade_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int SRC_W      = 32,
  parameter int BLK_SRC    = 12,
  parameter int IDX_W      = $clog2(SRC_W)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_GROUPS*SRC_W-1:0] srcIn,
  input  busStrb_t                    strb,
  input  logic [SRC_W-1:0]            wdata,
  output logic [SRC_W-1:0]            rdata,
  output logic [NUM_GROUPS-1:0]       grpIrq,
  output logic [GIDX_W-1:0]           irqGrp,
  output logic                        irqAny,
  output logic [NUM_GROUPS*IDX_W-1:0] vecWord
);
  localparam int ALL_W = NUM_GROUPS * SRC_W;

  logic [ALL_W-1:0] srcPrevQ;
  logic [ALL_W-1:0] statusAll;
  logic [ALL_W-1:0] enableAll;
  logic [ALL_W-1:0] pendAll;

  always_ff @(posedge clk) begin
    if (!rstN) srcPrevQ <= '0;
    else       srcPrevQ <= srcIn;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    // sources of group 0 below BLK_SRC behave as one unit
    localparam logic [SRC_W-1:0] BLK_MASK =
      (g == 0) ? SRC_W'((64'd1 << BLK_SRC) - 64'd1) : '0;

    logic             wrThis;
    logic [SRC_W-1:0] wrVal, ackBits, setBits, edgeBits;
    logic [SRC_W-1:0] statusQ, enableQ, pendG;
    logic [IDX_W-1:0] idxG;

    assign wrThis   = strb.wr && strb.grpHit && (strb.grp == GIDX_W'(g));
    assign wrVal    = (wdata & ~BLK_MASK) | ((|(wdata & BLK_MASK)) ? BLK_MASK : '0);
    assign edgeBits = srcIn[g*SRC_W +: SRC_W] & ~srcPrevQ[g*SRC_W +: SRC_W];
    assign ackBits  = (wrThis && strb.kind == RK_STATUS) ? wrVal : '0;
    assign setBits  = (wrThis && strb.kind == RK_SET)    ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ <= '0;
        enableQ <= '0;
      end else begin
        // set terms are ORed after the clear, so set wins
        statusQ <= (statusQ & ~ackBits) | setBits | edgeBits;
        if (wrThis && strb.kind == RK_ENABLE) enableQ <= wrVal;
      end
    end

    assign pendG = statusQ & enableQ;

    always_comb begin
      idxG = '0;
      for (int i = SRC_W - 1; i >= 0; i--) begin
        if (pendG[i]) idxG = IDX_W'(i);
      end
      if (|(pendG & BLK_MASK)) idxG = '0;
    end

    assign statusAll[g*SRC_W +: SRC_W] = statusQ;
    assign enableAll[g*SRC_W +: SRC_W] = enableQ;
    assign pendAll[g*SRC_W +: SRC_W]   = pendG;
    assign grpIrq[g]                   = |pendG;
    assign vecWord[g*IDX_W +: IDX_W]   = idxG;
  end

  always_comb begin
    irqGrp = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (grpIrq[g]) irqGrp = GIDX_W'(g);
    end
    irqAny = |grpIrq;
  end

  always_comb begin
    rdata = '0;
    if (strb.grpHit) begin
      case (strb.kind)
        RK_STATUS: rdata = statusAll[int'(strb.grp)*SRC_W +: SRC_W];
        RK_ENABLE: rdata = enableAll[int'(strb.grp)*SRC_W +: SRC_W];
        RK_PEND:   rdata = pendAll[int'(strb.grp)*SRC_W +: SRC_W];
        default:   rdata = '0;
      endcase
    end else if (strb.vecHit) begin
      rdata = SRC_W'(vecWord);
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int SRC_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int BLK_SRC    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_GROUPS*SRC_W-1:0] srcIn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [SRC_W-1:0]            busWdata,
  output logic [SRC_W-1:0]            busRdata,
  output logic [NUM_GROUPS-1:0]       cpuIrq,
  output logic                        irqAny,
  output logic [GIDX_W-1:0]           irqGrp
);
  localparam int IDX_W = $clog2(SRC_W);

  busStrb_t                    strb;
  logic [NUM_GROUPS*IDX_W-1:0] vecWord;

  irq_regctl #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W)
  ) ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  irq_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .SRC_W     (SRC_W),
    .BLK_SRC   (BLK_SRC),
    .IDX_W     (IDX_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strb   (strb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .grpIrq (cpuIrq),
    .irqGrp (irqGrp),
    .irqAny (irqAny),
    .vecWord(vecWord)
  );
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int SRC_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int BLK_SRC    = 12,
  parameter int IDX_W      = 5
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [ADDR_W-1:0]           busAddr,
  input logic                        busWe,
  input logic [SRC_W-1:0]            busRdata,
  input logic [NUM_GROUPS-1:0]       cpuIrq,
  input logic                        irqAny,
  input logic [GIDX_W-1:0]           irqGrp,
  input logic [NUM_GROUPS*IDX_W-1:0] vecWord
);
  logic enSeen;
  logic enWrite;

  assign enWrite = busWe && (busAddr[3:0] == 4'h4) &&
                   (busAddr[ADDR_W-1:4] >= (ADDR_W-4)'(1)) &&
                   (busAddr[ADDR_W-1:4] <= (ADDR_W-4)'(NUM_GROUPS));

  always_ff @(posedge clk) begin
    if (!rstN)        enSeen <= 1'b0;
    else if (enWrite) enSeen <= 1'b1;
  end

  // R1
  masked_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enSeen |-> (cpuIrq == '0));

  // R10
  any_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (cpuIrq != '0));

  // R10
  lowest_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAny |-> (cpuIrq[irqGrp] &&
                ((cpuIrq & NUM_GROUPS'((1 << irqGrp) - 1)) == '0)));

  // R9
  block_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecWord[IDX_W-1:0] == '0) || (int'(vecWord[IDX_W-1:0]) >= BLK_SRC));

  // R11
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(16)) |-> (busRdata == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gVec
    // R7
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
      !cpuIrq[g] |-> (vecWord[g*IDX_W +: IDX_W] == '0));
  end
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .SRC_W     (SRC_W),
  .ADDR_W    (ADDR_W),
  .BLK_SRC   (BLK_SRC),
  .IDX_W     (IDX_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busRdata (busRdata),
  .cpuIrq   (cpuIrq),
  .irqAny   (irqAny),
  .irqGrp   (irqGrp),
  .vecWord  (vecWord)
);

// File: tb/irq_cascade_ctrl_tb.sv
`timescale 1ns/100ps
module irq_cascade_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [159:0] srcIn = '0;
  logic [7:0]   busAddr = '0;
  logic         busWe = 1'b0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [4:0]   cpuIrq;
  logic         irqAny;
  logic [2:0]   irqGrp;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  bit    modelOn = 0;
  string curReq = "R1";

  // behavioural reference state
  bit [31:0]  mStat [5];
  bit [31:0]  mEn   [5];
  bit [159:0] mPrev;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cpuIrq(cpuIrq),
    .irqAny(irqAny), .irqGrp(irqGrp)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] mPend(int g);
    return mStat[g] & mEn[g];
  endfunction

  function automatic bit [4:0] mVec(int g);
    bit [31:0] p;
    p = mPend(g);
    if (g == 0 && (p & 32'hFFF) != 0) return 5'd0;
    for (int i = 0; i < 32; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic bit [31:0] mRead(bit [7:0] a);
    bit [31:0] v;
    int g;
    v = 0;
    if (a[1:0] != 0) return 0;
    if (a == 8'h60) begin
      for (int k = 0; k < 5; k++) v[k*5 +: 5] = mVec(k);
      return v;
    end
    if (a >= 8'h10 && a < 8'h60) begin
      g = a / 16 - 1;
      case (a[3:2])
        2'd0: v = mStat[g];
        2'd1: v = mEn[g];
        2'd2: v = mPend(g);
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  task automatic mStep();
    bit [31:0] ack, setb, w, edges;
    for (int g = 0; g < 5; g++) begin
      edges = srcIn[g*32 +: 32] & ~mPrev[g*32 +: 32];
      ack = 0;
      setb = 0;
      if (busWe && busAddr[1:0] == 0 && busAddr >= 8'h10 && busAddr < 8'h60 &&
          int'(busAddr) / 16 - 1 == g) begin
        w = busWdata;
        if (g == 0) w = (w & ~32'hFFF) | (((w & 32'hFFF) != 0) ? 32'hFFF : 32'h0);
        case (busAddr[3:2])
          2'd0: ack = w;
          2'd1: mEn[g] = w;
          2'd3: setb = busWdata;
          default: ;
        endcase
      end
      mStat[g] = (mStat[g] & ~ack) | setb | edges;
    end
    mPrev = srcIn;
  endtask

  task automatic compare();
    bit [4:0] expIrq;
    int expGrp;
    expGrp = 0;
    for (int g = 0; g < 5; g++) expIrq[g] = (mPend(g) != 0);
    for (int g = 4; g >= 0; g--) if (expIrq[g]) expGrp = g;
    check(curReq, "cpuIrq", 32'(cpuIrq), 32'(expIrq));
    check("R10", "irqAny", 32'(irqAny), 32'(expIrq != 0));
    if (expIrq != 0) check("R10", "irqGrp", 32'(irqGrp), 32'(expGrp));
    check(curReq, "busRdata", busRdata, mRead(busAddr));
  endtask

  // inputs change at the falling edge; outputs compared 1 ns later
  task automatic cycle();
    #1;
    if (modelOn) compare();
    @(posedge clk);
    if (modelOn) mStep();
    @(negedge clk);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    cycle();
    busWe = 1'b0;
  endtask

  task automatic expectRd(string req, bit [7:0] a, bit [31:0] exp);
    busAddr = a; busWe = 1'b0;
    #1;
    check(req, $sformatf("read 0x%02h", a), busRdata, exp);
    cycle();
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 5; g++) begin mStat[g] = 0; mEn[g] = 0; end
    mPrev = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1;

    // R1: reset state
    curReq = "R1";
    check("R1", "cpuIrq after reset", 32'(cpuIrq), 32'h0);
    expectRd("R1", 8'h14, 32'h0);
    expectRd("R1", 8'h60, 32'h0);

    // R3: edge captured while masked, line stays low (R6)
    curReq = "R3";
    srcIn[32+7] = 1'b1;
    cycle();
    expectRd("R3", 8'h20, 32'h80);
    check("R6", "cpuIrq masked", 32'(cpuIrq), 32'h0);

    // R6 / R7: enable and look at vector
    curReq = "R6";
    wr(8'h24, 32'h80);
    check("R6", "cpuIrq enabled", 32'(cpuIrq), 32'h02);
    expectRd("R6", 8'h28, 32'h80);
    expectRd("R7", 8'h60, 32'hE0);

    // R5: zeros leave bits, ones clear; R3 held level does not re-set
    curReq = "R5";
    wr(8'h20, 32'h7F);
    expectRd("R5", 8'h20, 32'h80);
    wr(8'h20, 32'h80);
    cycle();
    expectRd("R3", 8'h20, 32'h0);
    srcIn[32+7] = 1'b0;

    // R4: software set, set word reads 0 (R2)
    curReq = "R4";
    wr(8'h4C, 32'hA00);
    wr(8'h44, 32'hFFFF_FFFF);
    expectRd("R4", 8'h40, 32'hA00);
    expectRd("R2", 8'h4C, 32'h0);
    expectRd("R7", 8'h60, 32'h48000);
    check("R6", "cpuIrq group3", 32'(cpuIrq), 32'h08);

    // R10: two groups active
    curReq = "R10";
    wr(8'h3C, 32'h0010_0000);
    wr(8'h34, 32'h0010_0000);
    #1;
    check("R10", "irqGrp", 32'(irqGrp), 32'd2);
    expectRd("R7", 8'h60, 32'h4D000);

    // R5: edge and acknowledge in the same cycle, set wins
    curReq = "R5";
    srcIn[64+20] = 1'b1;
    wr(8'h30, 32'h0010_0000);
    srcIn[64+20] = 1'b0;
    expectRd("R5", 8'h30, 32'h0010_0000);
    wr(8'h30, 32'h0010_0000);
    expectRd("R5", 8'h30, 32'h0);

    // R8 / R9: group 0 block
    curReq = "R8";
    wr(8'h14, 32'h1);
    expectRd("R8", 8'h14, 32'hFFF);
    wr(8'h1C, 32'h20);
    #1;
    check("R10", "irqGrp group0", 32'(irqGrp), 32'd0);
    wr(8'h1C, 32'h1000);
    wr(8'h14, 32'h1001);
    expectRd("R9", 8'h60, 32'h48000);
    wr(8'h10, 32'h8);
    expectRd("R8", 8'h10, 32'h1000);
    expectRd("R9", 8'h60, 32'h4800C);
    wr(8'h14, 32'h1000);
    expectRd("R8", 8'h14, 32'h1000);

    // R11: ignored writes
    curReq = "R11";
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h48, 32'h0);
    wr(8'h60, 32'h0);
    expectRd("R11", 8'h10, 32'h1000);
    expectRd("R11", 8'h14, 32'h1000);
    expectRd("R11", 8'h48, 32'hA00);
    expectRd("R11", 8'h60, 32'h4800C);
    expectRd("R11", 8'h00, 32'h0);
    expectRd("R11", 8'h70, 32'h0);
    expectRd("R11", 8'h11, 32'h0);

    // random traffic against the model
    curReq = "R6";
    for (int n = 0; n < 4000; n++) begin
      busAddr  = ($urandom % 8 == 0) ? 8'($urandom) : 8'(16 + 4 * ($urandom % 21));
      busWe    = ($urandom % 2) == 1;
      busWdata = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
      srcIn[$urandom % 160] ^= 1'b1;
      cycle();
    end
    busWe = 1'b0;
    cycle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule